// File: doc/BRIEF.md
# Interrupt Pending Tracker

This block sits beside a processor's instruction sequencer and turns raw interrupt activity into two pending flags that the sequencer looks at between instructions. The non-maskable request arrives as a level. It is sampled once per processor cycle, marked by a clock enable, and a low-to-high transition latches a "needs service" bit. The maskable requests arrive as per-source set and clear strobes on an 8-bit source mask. The sequencer can ask whether any single source is present.

The pending outputs are pipelined. On each processor cycle the block first copies the previously latched non-maskable request into `nmi_pend`. It also copies "any source present and interrupts not disabled" into `irq_pend`. Edge detection for the current cycle then finishes. A one-shot lock request makes the next processor cycle skip this copy, so both pending flags keep their values for one cycle longer. When the sequencer has taken the non-maskable interrupt it pulses an acknowledge to clear the latched request. While `irq_pend` is high, a cycle the sequencer marks as idle is reported as a dummy program-counter read.

Top module: `irq_pend_unit`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `need_nmi`, `nmi_pend`, `irq_pend` and `irq_src` are all zero. The stored previous NMI sample is low, so an `nmi_lvl` that is high at the first enabled cycle counts as an edge.
- R2: On a clock with `cyc_en` high, `need_nmi` becomes 1 if `nmi_lvl` is 1 and the value sampled at the previous enabled clock was 0. A level held high produces no second edge.
- R3: On an enabled, unlocked clock, `nmi_pend` takes the value `need_nmi` had just before that clock.
- R4: On an enabled, unlocked clock, `irq_pend` takes (any bit of `irq_src` set just before that clock) AND NOT `irq_dis` sampled at that clock.
- R5: A `lock_req` pulse arms a one-shot lock. The next enabled clock, which may be the same clock, leaves `nmi_pend` and `irq_pend` unchanged and disarms the lock. The enabled clock after that updates them normally.
- R6: On every clock, each bit set in `irq_set` is ORed into `irq_src` and each bit set in `irq_clr` is removed. When both strobes hit the same bit in the same clock, the set wins.
- R7: `query_hit` equals bit `query_sel` of `irq_src` (bit 0 is the least significant source).
- R8: `nmi_ack` clears `need_nmi` at the next clock, on any clock, unless an edge is detected on that same clock. In that case `need_nmi` stays 1.
- R9: `dummy_read` is high exactly when `idle_cyc` and `irq_pend` are both high.
- R10: On a clock with `cyc_en` low, `nmi_pend`, `irq_pend` and the previous-sample register keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | One pulse per processor cycle |
| nmi_lvl | input | 1 | Non-maskable request level |
| nmi_ack | input | 1 | Non-maskable request handled, clears the latch |
| irq_set | input | 8 | Source bits to add |
| irq_clr | input | 8 | Source bits to remove |
| irq_dis | input | 1 | Maskable interrupt disable flag |
| lock_req | input | 1 | Arm a one-shot hold of the pending flags |
| idle_cyc | input | 1 | Sequencer is about to run an idle cycle |
| query_sel | input | 3 | Source index to query |
| query_hit | output | 1 | Queried source is present |
| irq_src | output | 8 | Current source mask |
| need_nmi | output | 1 | Latched non-maskable edge |
| nmi_pend | output | 1 | Delayed non-maskable pending flag |
| irq_pend | output | 1 | Delayed, masked maskable pending flag |
| dummy_read | output | 1 | Idle cycle becomes a program-counter read |

## Verification
On every cycle, the assertions check that edges latch, that the pending copy lags `need_nmi` by one enabled cycle, and that the disable flag masks the maskable copy. They also check that a locked or disabled cycle holds the pending flags and that set strobes land in the mask. Only the bench's scenarios show how these interact: a lock armed while `cyc_en` is low, an acknowledge that lands on a fresh edge, set and clear colliding on one bit, and a level held high across many cycles. The bench's behavioural model shows these by comparing every output on every clock.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

  localparam int unsigned SRC_W_DEF = 8;

  // low-to-high transition between two samples
  function automatic logic rise_seen(input logic prev_s, input logic cur_s);
    return cur_s & ~prev_s;
  endfunction

  // maskable request after the disable gate
  function automatic logic irq_request(input logic any_src, input logic dis);
    return any_src & ~dis;
  endfunction

  // one source bit: set takes priority over clear
  function automatic logic src_bit_next(input logic cur, input logic set_b, input logic clr_b);
    return set_b | (cur & ~clr_b);
  endfunction

endpackage

// File: rtl/nmi_edge_det.sv
module nmi_edge_det
  import irq_pend_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic nmi_lvl,
  input  logic nmi_ack,
  output logic nmi_prev,
  output logic nmi_edge,
  output logic need_nmi
);

  logic prev_q;
  logic need_q;

  assign nmi_edge = cyc_en & rise_seen(prev_q, nmi_lvl);
  assign nmi_prev = prev_q;
  assign need_nmi = need_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      need_q <= 1'b0;
    end else begin
      if (cyc_en) prev_q <= nmi_lvl;
      need_q <= nmi_edge | (need_q & ~nmi_ack);
    end
  end

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_pend_pkg::*;
#(
  parameter int unsigned SRC_W = SRC_W_DEF,
  localparam int unsigned SEL_W = (SRC_W > 1) ? $clog2(SRC_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] set_mask,
  input  logic [SRC_W-1:0] clr_mask,
  input  logic [SEL_W-1:0] sel,
  output logic [SRC_W-1:0] src,
  output logic             hit,
  output logic             any
);

  logic [SRC_W-1:0] src_q;

  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) src_q[i] <= 1'b0;
      else        src_q[i] <= src_bit_next(src_q[i], set_mask[i], clr_mask[i]);
    end
  end

  assign src = src_q;
  assign any = |src_q;
  assign hit = src_q[sel];

endmodule

// File: rtl/pend_stage.sv
module pend_stage
  import irq_pend_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic lock_req,
  input  logic need_nmi,
  input  logic irq_any,
  input  logic irq_dis,
  output logic lock_eff,
  output logic nmi_pend,
  output logic irq_pend
);

  logic armed_q;
  logic nmi_q;
  logic irq_q;

  assign lock_eff = armed_q | lock_req;
  assign nmi_pend = nmi_q;
  assign irq_pend = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      nmi_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else if (cyc_en) begin
      armed_q <= 1'b0;
      if (!lock_eff) begin
        nmi_q <= need_nmi;
        irq_q <= irq_request(irq_any, irq_dis);
      end
    end else if (lock_req) begin
      armed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit
  import irq_pend_pkg::*;
#(
  parameter int unsigned SRC_W = SRC_W_DEF,
  localparam int unsigned SEL_W = (SRC_W > 1) ? $clog2(SRC_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             nmi_lvl,
  input  logic             nmi_ack,
  input  logic [SRC_W-1:0] irq_set,
  input  logic [SRC_W-1:0] irq_clr,
  input  logic             irq_dis,
  input  logic             lock_req,
  input  logic             idle_cyc,
  input  logic [SEL_W-1:0] query_sel,
  output logic             query_hit,
  output logic [SRC_W-1:0] irq_src,
  output logic             need_nmi,
  output logic             nmi_pend,
  output logic             irq_pend,
  output logic             dummy_read
);

  logic nmi_prev;
  logic nmi_edge;
  logic irq_any;
  logic lock_eff;

  nmi_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_en   (cyc_en),
    .nmi_lvl  (nmi_lvl),
    .nmi_ack  (nmi_ack),
    .nmi_prev (nmi_prev),
    .nmi_edge (nmi_edge),
    .need_nmi (need_nmi)
  );

  irq_src_bank #(.SRC_W(SRC_W)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mask (irq_set),
    .clr_mask (irq_clr),
    .sel      (query_sel),
    .src      (irq_src),
    .hit      (query_hit),
    .any      (irq_any)
  );

  pend_stage u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_en   (cyc_en),
    .lock_req (lock_req),
    .need_nmi (need_nmi),
    .irq_any  (irq_any),
    .irq_dis  (irq_dis),
    .lock_eff (lock_eff),
    .nmi_pend (nmi_pend),
    .irq_pend (irq_pend)
  );

  assign dummy_read = idle_cyc & irq_pend;

endmodule

// File: rtl/irq_pend_checker.sv
module irq_pend_checker #(
  parameter int unsigned SRC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_en,
  input logic             nmi_lvl,
  input logic             nmi_prev,
  input logic             irq_dis,
  input logic             lock_eff,
  input logic [SRC_W-1:0] irq_set,
  input logic [SRC_W-1:0] irq_src,
  input logic             need_nmi,
  input logic             nmi_pend,
  input logic             irq_pend
);

  p_edge_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && nmi_lvl && !nmi_prev) |=> need_nmi);

  p_nmi_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !lock_eff) |=> (nmi_pend == $past(need_nmi)));

  p_irq_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !lock_eff && irq_dis) |=> !irq_pend);

  p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && lock_eff) |=> ($stable(nmi_pend) && $stable(irq_pend)));

  p_set_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_set) |=> ((irq_src & $past(irq_set)) == $past(irq_set)));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> ($stable(nmi_pend) && $stable(irq_pend) && $stable(nmi_prev)));

endmodule

bind irq_pend_unit irq_pend_checker #(.SRC_W(SRC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cyc_en   (cyc_en),
  .nmi_lvl  (nmi_lvl),
  .nmi_prev (nmi_prev),
  .irq_dis  (irq_dis),
  .lock_eff (lock_eff),
  .irq_set  (irq_set),
  .irq_src  (irq_src),
  .need_nmi (need_nmi),
  .nmi_pend (nmi_pend),
  .irq_pend (irq_pend)
);

// File: tb/tb_irq_pend_unit.sv
module tb_irq_pend_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0, nmi_lvl = 1'b0, nmi_ack = 1'b0;
  logic [7:0] irq_set = '0, irq_clr = '0;
  logic       irq_dis = 1'b0, lock_req = 1'b0, idle_cyc = 1'b0;
  logic [2:0] query_sel = '0;
  logic       query_hit, need_nmi, nmi_pend, irq_pend, dummy_read;
  logic [7:0] irq_src;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  bit       m_prev, m_need, m_np, m_ip, m_arm;
  bit [7:0] m_src;

  always #4 clk = ~clk;

  irq_pend_unit dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .nmi_lvl(nmi_lvl), .nmi_ack(nmi_ack),
    .irq_set(irq_set), .irq_clr(irq_clr), .irq_dis(irq_dis), .lock_req(lock_req),
    .idle_cyc(idle_cyc), .query_sel(query_sel), .query_hit(query_hit), .irq_src(irq_src),
    .need_nmi(need_nmi), .nmi_pend(nmi_pend), .irq_pend(irq_pend), .dummy_read(dummy_read)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R2", "need_nmi", int'(need_nmi), int'(m_need));
    check("R3", "nmi_pend", int'(nmi_pend), int'(m_np));
    check("R4", "irq_pend", int'(irq_pend), int'(m_ip));
    check("R6", "irq_src", int'(irq_src), int'(m_src));
    check("R7", "query_hit", int'(query_hit), int'(m_src[query_sel]));
    check("R9", "dummy_read", int'(dummy_read), int'(idle_cyc && m_ip));
  endtask

  // apply one clock of inputs: drive after negedge, compare, advance model at posedge
  task automatic step(input bit c, input bit n, input bit ack, input bit [7:0] s,
                      input bit [7:0] k, input bit d, input bit l, input bit idl,
                      input bit [2:0] q);
    bit edge_now, lk;
    cyc_en = c; nmi_lvl = n; nmi_ack = ack; irq_set = s; irq_clr = k;
    irq_dis = d; lock_req = l; idle_cyc = idl; query_sel = q;
    #1;
    compare_all();
    edge_now = c && n && !m_prev;
    lk = m_arm || l;
    if (c) begin
      if (!lk) begin
        m_np = m_need;
        m_ip = (m_src != 0) && !d;
      end
      m_arm = 0;
      m_prev = n;
    end else if (l) m_arm = 1;
    m_need = edge_now || (m_need && !ack);
    for (int i = 0; i < 8; i++) m_src[i] = s[i] || (m_src[i] && !k[i]);
    @(negedge clk);
  endtask

  task automatic idle_step(input bit c);
    step(c, nmi_lvl, 0, 8'h00, 8'h00, irq_dis, 0, 0, 3'd0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_prev = 0; m_need = 0; m_np = 0; m_ip = 0; m_arm = 0; m_src = '0;
    repeat (3) @(negedge clk);
    // R1: reset values while held
    check("R1", "need_nmi in reset", int'(need_nmi), 0);
    check("R1", "pendings in reset", int'({nmi_pend, irq_pend}), 0);
    check("R1", "irq_src in reset", int'(irq_src), 0);
    rst_n = 1'b1;

    // R1/R2: level already high at first enabled cycle is an edge
    step(1, 1, 0, 0, 0, 0, 0, 0, 0);
    check("R1", "edge after reset", int'(need_nmi), 1);
    step(1, 1, 0, 0, 0, 0, 0, 0, 0);
    check("R3", "nmi_pend one step later", int'(nmi_pend), 1);
    // R8: ack clears, held level gives no new edge
    step(0, 1, 1, 0, 0, 0, 0, 0, 0);
    check("R8", "ack clears need", int'(need_nmi), 0);
    step(1, 1, 0, 0, 0, 0, 0, 0, 0);
    check("R2", "held level no edge", int'(need_nmi), 0);
    // R8: ack colliding with a fresh edge keeps need
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0, 0, 0, 0);
    check("R8", "edge beats ack", int'(need_nmi), 1);

    // R6: set wins over clear on the same bit
    step(0, 0, 0, 8'h05, 8'h00, 0, 0, 0, 0);
    step(0, 0, 0, 8'h04, 8'h05, 0, 0, 0, 2);
    check("R6", "set beats clear", int'(irq_src), 8'h04);
    step(0, 0, 0, 0, 0, 0, 0, 0, 2);
    check("R7", "query bit 2", int'(query_hit), 1);

    // R10: disabled cycles hold pendings
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R10", "no update without cyc_en", int'(irq_pend), 0);
    // R5: lock armed while idle holds the next enabled cycle
    step(0, 0, 0, 0, 0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R5", "locked step holds irq_pend", int'(irq_pend), 0);
    step(1, 0, 0, 0, 0, 0, 0, 1, 0);
    check("R5", "unlocked step updates irq_pend", int'(irq_pend), 1);
    check("R9", "dummy read on idle", int'(dummy_read), 1);
    // R4: disable masks
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);
    check("R4", "disable masks irq", int'(irq_pend), 0);

    // random phase
    for (int it = 0; it < 4000; it++) begin
      step(($urandom % 10) < 7, ($urandom % 4) == 0, ($urandom % 8) == 0,
           (($urandom % 4) == 0) ? 8'($urandom) : 8'h00,
           (($urandom % 3) == 0) ? 8'($urandom) : 8'h00,
           ($urandom % 3) == 0, ($urandom % 10) == 0, ($urandom % 2) == 0,
           3'($urandom));
    end
    cyc_en = 0; lock_req = 0; irq_set = 0; irq_clr = 0; nmi_ack = 0;
    #1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule